// File: doc/BRIEF.md
# Miss Tracking Entry Pool

This block keeps a fixed set of entries that record the cache misses a non-blocking cache has sent out or is about to send. Each entry holds a block address, an access size, a secure bit, a thread id, the time at which it may be issued and a flag that shows it is in service. The cache issues one command per cycle to the pool: allocate, release, mark in service, re-pend, move to the head, squash a thread, pop a target or request a drain. In the same cycle it can look up the pool without side effects.

Two lookups are combinational. The exact lookup finds a tracked block by address and secure bit. The overlap lookup finds a waiting entry whose byte range meets a requested range. The pool always presents the next entry to issue, which is the waiting entry with the earliest ready time. Move-to-head overrides that order. Status outputs report full, empty, allocation error, a one-cycle "room again" pulse after a target pop, and the drain handshake.

Target lists stay outside the block. The cache tells the pool through a flag whether a popped entry has targets left, and whether an entry being put in service needs a response.

Top module: `mshr_file`

## Requirements
- R1: The pool has REQ_ENTRIES + RESERVE - 1 entries. `full` is high exactly when all of them are allocated. `alloc_idx` shows the entry the next allocation (command code 1) will take. After reset this is entry 0, then 1, 2 and so on.
- R2: An allocation while `full` changes no entry. It raises `alloc_err` for one cycle.
- R3: The exact lookup hits only on an allocated entry whose address and secure bit both equal the lookup's. Among several hits it returns the entry allocated earliest.
- R4: The overlap lookup considers only entries that are waiting (allocated and not in service) and whose secure bit matches. For such an entry at base B with size S and a lookup at A with size Q: when B < A it hits if B+S > A, and otherwise it hits if A+Q > B. Among hits it returns the one first in issue order.
- R5: `issue_idx` names the waiting entry with the smallest ready time. Equal ready times go to the entry that entered the order first.
- R6: Move-to-head (code 5) puts a waiting entry at the head of the issue order. It has no effect on an entry in service.
- R7: Mark-in-service (code 3) removes a waiting entry from the issue order and raises `svc_cnt` by one. With `cmd_flag` set, the entry is released instead.
- R8: Re-pend (code 4) of an entry in service clears its in-service flag and lowers `svc_cnt`. It puts the entry back in the order behind every waiting entry whose ready time is less than or equal to its own.
- R9: Release (code 2) frees an allocated entry and lowers `alloc_cnt`, and it lowers `svc_cnt` if the entry was in service. The freed entry becomes the next one allocated.
- R10: A drain request (code 8) with no entries allocated sets `drained` on the next cycle. Otherwise `drain_done` pulses for one cycle, with `drained` set, in the cycle after the count first reaches zero. The next allocation clears `drained`.
- R11: Squash (code 6) with thread id `cmd_tid` frees every waiting entry of that thread. Entries of that thread that are in service stay allocated.
- R12: Target pop (code 7) frees the entry only when `cmd_flag` says no targets remain. `unfull_pulse` is high for one cycle only if the pool was full before the pop and is not full after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | active-low synchronous reset |
| cmd_op | input | 4 | command code, 0 is no operation |
| cmd_idx | input | IDX_W | entry the command acts on |
| cmd_addr | input | ADDR_W | block address for allocation |
| cmd_size | input | SIZE_W | access size in bytes for allocation |
| cmd_secure | input | 1 | secure bit for allocation |
| cmd_tid | input | TID_W | thread id for allocation and squash |
| cmd_time | input | TIME_W | ready time for allocation |
| cmd_flag | input | 1 | no-response flag (code 3) or no-targets-left flag (code 7) |
| lk_addr | input | ADDR_W | lookup address |
| lk_size | input | SIZE_W | lookup size for the overlap lookup |
| lk_secure | input | 1 | lookup secure bit |
| match_hit | output | 1 | exact lookup hit |
| match_idx | output | IDX_W | exact lookup entry |
| ovl_hit | output | 1 | overlap lookup hit |
| ovl_idx | output | IDX_W | overlap lookup entry |
| issue_valid | output | 1 | a waiting entry exists |
| issue_idx | output | IDX_W | next entry to issue |
| alloc_idx | output | IDX_W | entry the next allocation takes |
| full | output | 1 | all entries allocated |
| empty | output | 1 | no entry allocated |
| alloc_cnt | output | CNT_W | allocated entries |
| svc_cnt | output | CNT_W | entries in service |
| alloc_err | output | 1 | pulse: allocation refused |
| unfull_pulse | output | 1 | pulse: a pop freed a full pool |
| drained | output | 1 | drain completed |
| drain_done | output | 1 | pulse: pending drain completed |

## Verification
The hardest state to reach is a re-pended entry whose ready time ties with a waiting entry while a third entry sits at the head from a move-to-head. Reaching it takes a fixed chain of allocations, services and re-pends. The bench then services entries one at a time to expose the order behind the head. The "room again" pulse needs the pool genuinely full when a pop frees an entry. The bench therefore fills all five entries and contrasts that pop with a later one taken from a pool that is not full. The overlap rule is swept over every address around an entry and every request size, for both secure values.

// File: rtl/mshr_pkg.sv
package mshr_pkg;
   typedef enum logic [3:0] {
      OP_NOP     = 4'd0,
      OP_ALLOC   = 4'd1,
      OP_RELEASE = 4'd2,
      OP_SERVE   = 4'd3,
      OP_REPEND  = 4'd4,
      OP_TOHEAD  = 4'd5,
      OP_SQUASH  = 4'd6,
      OP_POP     = 4'd7,
      OP_DRAIN   = 4'd8
   } mshr_op_e;
endpackage

// File: rtl/mshr_pick_min.sv
module mshr_pick_min #(
   parameter int N     = 4,
   parameter int KEY_W = 8,
   parameter int IW    = 2
) (
   input  logic [N-1:0]            cand,
   input  logic [N-1:0][KEY_W-1:0] key,
   output logic                    hit,
   output logic [IW-1:0]           idx
);
   logic [KEY_W-1:0] best;

   // lowest key wins, equal keys go to the lower index
   always_comb begin
      hit  = 1'b0;
      idx  = '0;
      best = '0;
      for (int i = 0; i < N; i++) begin
         if (cand[i] && (!hit || key[i] < best)) begin
            hit  = 1'b1;
            idx  = IW'(i);
            best = key[i];
         end
      end
   end
endmodule

// File: rtl/mshr_range_cmp.sv
module mshr_range_cmp #(
   parameter int AW = 32,
   parameter int SW = 8
) (
   input  logic          e_valid,
   input  logic          e_insvc,
   input  logic          e_secure,
   input  logic [AW-1:0] e_addr,
   input  logic [SW-1:0] e_size,
   input  logic          q_secure,
   input  logic [AW-1:0] q_addr,
   input  logic [SW-1:0] q_size,
   output logic          exact,
   output logic          overlap
);
   logic [AW:0] e_end, q_end;

   assign e_end = {1'b0, e_addr} + {{(AW+1-SW){1'b0}}, e_size};
   assign q_end = {1'b0, q_addr} + {{(AW+1-SW){1'b0}}, q_size};

   assign exact = e_valid && (e_addr == q_addr) && (e_secure == q_secure);

   always_comb begin
      overlap = 1'b0;
      if (e_valid && !e_insvc && (e_secure == q_secure)) begin
         if (e_addr < q_addr) overlap = e_end > {1'b0, q_addr};
         else                 overlap = q_end > {1'b0, e_addr};
      end
   end
endmodule

// File: rtl/mshr_file.sv
module mshr_file #(
   parameter int REQ_ENTRIES = 8,
   parameter int RESERVE     = 4,
   parameter int ADDR_W      = 32,
   parameter int SIZE_W      = 8,
   parameter int TID_W       = 4,
   parameter int TIME_W      = 16,
   parameter int SEQ_W       = 16,
   parameter bit LIFO_FREE   = 1'b1,
   localparam int NUM   = REQ_ENTRIES + RESERVE - 1,
   localparam int IDX_W = (NUM > 1) ? $clog2(NUM) : 1,
   localparam int CNT_W = $clog2(NUM + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [3:0]        cmd_op,
   input  logic [IDX_W-1:0]  cmd_idx,
   input  logic [ADDR_W-1:0] cmd_addr,
   input  logic [SIZE_W-1:0] cmd_size,
   input  logic              cmd_secure,
   input  logic [TID_W-1:0]  cmd_tid,
   input  logic [TIME_W-1:0] cmd_time,
   input  logic              cmd_flag,
   input  logic [ADDR_W-1:0] lk_addr,
   input  logic [SIZE_W-1:0] lk_size,
   input  logic              lk_secure,
   output logic              match_hit,
   output logic [IDX_W-1:0]  match_idx,
   output logic              ovl_hit,
   output logic [IDX_W-1:0]  ovl_idx,
   output logic              issue_valid,
   output logic [IDX_W-1:0]  issue_idx,
   output logic [IDX_W-1:0]  alloc_idx,
   output logic              full,
   output logic              empty,
   output logic [CNT_W-1:0]  alloc_cnt,
   output logic [CNT_W-1:0]  svc_cnt,
   output logic              alloc_err,
   output logic              unfull_pulse,
   output logic              drained,
   output logic              drain_done
);
   import mshr_pkg::*;

   localparam int MAXW   = (TIME_W > SEQ_W) ? TIME_W : SEQ_W;
   localparam int ORD_W  = 1 + MAXW + SEQ_W;
   localparam int FREE_W = 2 * SEQ_W;

   generate
      if (REQ_ENTRIES < 1 || RESERVE < 1) begin : g_bad_count
         $error("mshr_file: REQ_ENTRIES and RESERVE must be at least 1");
      end
      if (SIZE_W > ADDR_W) begin : g_bad_size
         $error("mshr_file: SIZE_W must not exceed ADDR_W");
      end
      if (SEQ_W < $clog2(NUM + 1)) begin : g_bad_seq
         $error("mshr_file: SEQ_W too small for the entry count");
      end
   endgenerate

   typedef struct packed {
      logic              valid;
      logic              insvc;
      logic              front;
      logic              secure;
      logic [ADDR_W-1:0] addr;
      logic [SIZE_W-1:0] size;
      logic [TID_W-1:0]  tid;
      logic [TIME_W-1:0] ready;
      logic [SEQ_W-1:0]  ins_seq;
      logic [SEQ_W-1:0]  alloc_seq;
      logic [SEQ_W-1:0]  fstamp;
   } ent_t;

   ent_t [NUM-1:0] ent_q, ent_d;
   logic [SEQ_W-1:0] ctr_q;
   logic draining_q, drained_q, alloc_err_q, unfull_q, drain_done_q;

   mshr_op_e op;
   assign op = mshr_op_e'(cmd_op);

   logic [NUM-1:0] valid_v, wait_v, valid_d, exact_v, ovl_v, free_v;
   logic [NUM-1:0][ORD_W-1:0]  ord_key;
   logic [NUM-1:0][SEQ_W-1:0]  age_key;
   logic [NUM-1:0][FREE_W-1:0] free_key;
   logic free_hit;

   genvar gi;
   generate
      for (gi = 0; gi < NUM; gi++) begin : g_ent
         assign valid_v[gi] = ent_q[gi].valid;
         assign wait_v[gi]  = ent_q[gi].valid && !ent_q[gi].insvc;
         assign free_v[gi]  = !ent_q[gi].valid;
         assign valid_d[gi] = ent_d[gi].valid;
         assign age_key[gi] = ent_q[gi].alloc_seq;
         // head entries first (newest head first), then ready time, then arrival
         assign ord_key[gi] = ent_q[gi].front
            ? {1'b0, MAXW'(~ent_q[gi].ins_seq), ent_q[gi].ins_seq}
            : {1'b1, MAXW'(ent_q[gi].ready),    ent_q[gi].ins_seq};
         if (LIFO_FREE) begin : g_lifo
            assign free_key[gi] = ~{ent_q[gi].fstamp, ent_q[gi].alloc_seq};
         end else begin : g_lowest
            assign free_key[gi] = '0;
         end
         mshr_range_cmp #(.AW(ADDR_W), .SW(SIZE_W)) u_cmp (
            .e_valid (ent_q[gi].valid),
            .e_insvc (ent_q[gi].insvc),
            .e_secure(ent_q[gi].secure),
            .e_addr  (ent_q[gi].addr),
            .e_size  (ent_q[gi].size),
            .q_secure(lk_secure),
            .q_addr  (lk_addr),
            .q_size  (lk_size),
            .exact   (exact_v[gi]),
            .overlap (ovl_v[gi])
         );
      end
   endgenerate

   mshr_pick_min #(.N(NUM), .KEY_W(ORD_W), .IW(IDX_W)) u_issue (
      .cand(wait_v), .key(ord_key), .hit(issue_valid), .idx(issue_idx));
   mshr_pick_min #(.N(NUM), .KEY_W(ORD_W), .IW(IDX_W)) u_ovl (
      .cand(ovl_v), .key(ord_key), .hit(ovl_hit), .idx(ovl_idx));
   mshr_pick_min #(.N(NUM), .KEY_W(SEQ_W), .IW(IDX_W)) u_match (
      .cand(exact_v), .key(age_key), .hit(match_hit), .idx(match_idx));
   mshr_pick_min #(.N(NUM), .KEY_W(FREE_W), .IW(IDX_W)) u_free (
      .cand(free_v), .key(free_key), .hit(free_hit), .idx(alloc_idx));

   assign full      = !free_hit;
   assign empty     = !(|valid_v);
   assign alloc_cnt = CNT_W'($countones(valid_v));
   assign svc_cnt   = CNT_W'($countones(valid_v & ~wait_v));

   function automatic ent_t release_ent(ent_t e, logic [SEQ_W-1:0] st);
      ent_t r;
      r        = e;
      r.valid  = 1'b0;
      r.insvc  = 1'b0;
      r.front  = 1'b0;
      r.fstamp = st;
      return r;
   endfunction

   logic             idx_ok;
   logic [IDX_W-1:0] ci;
   ent_t             sel;
   assign idx_ok = int'(cmd_idx) < NUM;
   assign ci     = idx_ok ? cmd_idx : '0;
   assign sel    = ent_q[ci];

   always_comb begin
      ent_d = ent_q;
      unique case (op)
         OP_ALLOC: if (!full) begin
            ent_d[alloc_idx].valid     = 1'b1;
            ent_d[alloc_idx].insvc     = 1'b0;
            ent_d[alloc_idx].front     = 1'b0;
            ent_d[alloc_idx].secure    = cmd_secure;
            ent_d[alloc_idx].addr      = cmd_addr;
            ent_d[alloc_idx].size      = cmd_size;
            ent_d[alloc_idx].tid       = cmd_tid;
            ent_d[alloc_idx].ready     = cmd_time;
            ent_d[alloc_idx].ins_seq   = ctr_q;
            ent_d[alloc_idx].alloc_seq = ctr_q;
         end
         OP_RELEASE: if (idx_ok && sel.valid)
            ent_d[ci] = release_ent(sel, ctr_q);
         OP_SERVE: if (idx_ok && sel.valid && !sel.insvc) begin
            if (cmd_flag) ent_d[ci] = release_ent(sel, ctr_q);
            else begin
               ent_d[ci].insvc = 1'b1;
               ent_d[ci].front = 1'b0;
            end
         end
         OP_REPEND: if (idx_ok && sel.valid && sel.insvc) begin
            ent_d[ci].insvc   = 1'b0;
            ent_d[ci].front   = 1'b0;
            ent_d[ci].ins_seq = ctr_q;
         end
         OP_TOHEAD: if (idx_ok && sel.valid && !sel.insvc) begin
            ent_d[ci].front   = 1'b1;
            ent_d[ci].ins_seq = ctr_q;
         end
         OP_SQUASH:
            for (int i = 0; i < NUM; i++)
               if (ent_q[i].valid && !ent_q[i].insvc && ent_q[i].tid == cmd_tid)
                  ent_d[i] = release_ent(ent_q[i], ctr_q);
         OP_POP: if (idx_ok && sel.valid && cmd_flag)
            ent_d[ci] = release_ent(sel, ctr_q);
         default: ;
      endcase
   end

   logic now_clear;
   assign now_clear = !(|valid_d);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < NUM; i++) begin
            ent_q[i]        <= '0;
            ent_q[i].fstamp <= SEQ_W'(NUM - 1 - i);
         end
         ctr_q        <= SEQ_W'(NUM);
         draining_q   <= 1'b0;
         drained_q    <= 1'b0;
         alloc_err_q  <= 1'b0;
         unfull_q     <= 1'b0;
         drain_done_q <= 1'b0;
      end else begin
         ent_q        <= ent_d;
         if (op != OP_NOP) ctr_q <= ctr_q + 1'b1;
         alloc_err_q  <= (op == OP_ALLOC) && full;
         unfull_q     <= (op == OP_POP) && full && !(&valid_d);
         drain_done_q <= draining_q && now_clear;
         if (draining_q && now_clear) begin
            draining_q <= 1'b0;
            drained_q  <= 1'b1;
         end else if (op == OP_DRAIN) begin
            if (empty) drained_q  <= 1'b1;
            else       draining_q <= 1'b1;
         end else if (op == OP_ALLOC && !full) begin
            drained_q <= 1'b0;
         end
      end
   end

   assign alloc_err    = alloc_err_q;
   assign unfull_pulse = unfull_q;
   assign drained      = drained_q;
   assign drain_done   = drain_done_q;
endmodule

// File: rtl/mshr_file_chk.sv
module mshr_file_chk #(
   parameter int NUM   = 4,
   parameter int CNT_W = 3
) (
   input logic             clk,
   input logic             rst_n,
   input logic [3:0]       cmd_op,
   input logic             full,
   input logic             empty,
   input logic [CNT_W-1:0] alloc_cnt,
   input logic [CNT_W-1:0] svc_cnt,
   input logic             issue_valid,
   input logic             match_hit,
   input logic             ovl_hit,
   input logic             alloc_err,
   input logic             unfull_pulse,
   input logic             drained,
   input logic             drain_done
);
   AST_FULL_NOT_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
      full |-> !empty);                                              // R1
   AST_FULL_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
      full == (int'(alloc_cnt) == NUM));                             // R1
   AST_ALLOC_ERR_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
      alloc_err |-> ($past(full) && $past(cmd_op) == 4'd1));         // R2
   AST_ALLOC_ERR_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
      alloc_err |-> $stable(alloc_cnt));                             // R2
   AST_EMPTY_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      empty |-> (!issue_valid && !match_hit && !ovl_hit));           // R3
   AST_ISSUE_WAITING: assert property (@(posedge clk) disable iff (!rst_n)
      issue_valid |-> (alloc_cnt > svc_cnt));                        // R5
   AST_SVC_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      svc_cnt <= alloc_cnt);                                         // R7
   AST_DRAIN_DONE: assert property (@(posedge clk) disable iff (!rst_n)
      drain_done |-> (empty && drained));                            // R10
   AST_UNFULL: assert property (@(posedge clk) disable iff (!rst_n)
      unfull_pulse |-> ($past(full) && !full));                      // R12
endmodule

bind mshr_file mshr_file_chk #(.NUM(NUM), .CNT_W(CNT_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .cmd_op(cmd_op), .full(full), .empty(empty),
   .alloc_cnt(alloc_cnt), .svc_cnt(svc_cnt), .issue_valid(issue_valid),
   .match_hit(match_hit), .ovl_hit(ovl_hit), .alloc_err(alloc_err),
   .unfull_pulse(unfull_pulse), .drained(drained), .drain_done(drain_done));

// File: tb/mshr_file_test.sv
module mshr_file_test;
   localparam int CLK_PERIOD = 10;
   localparam int AW = 8, SW = 4, TW = 2, MW = 8;

   logic clk = 1'b0, rst_n = 1'b0;
   logic [3:0] cmd_op = '0;
   logic [2:0] cmd_idx = '0;
   logic [AW-1:0] cmd_addr = '0, lk_addr = '0;
   logic [SW-1:0] cmd_size = '0, lk_size = '0;
   logic cmd_secure = 1'b0, cmd_flag = 1'b0, lk_secure = 1'b0;
   logic [TW-1:0] cmd_tid = '0;
   logic [MW-1:0] cmd_time = '0;
   logic match_hit, ovl_hit, issue_valid, full, empty;
   logic alloc_err, unfull_pulse, drained, drain_done;
   logic [2:0] match_idx, ovl_idx, issue_idx, alloc_idx, alloc_cnt, svc_cnt;

   int n_run = 0, n_fail = 0;
   bit finished = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   mshr_file #(.REQ_ENTRIES(4), .RESERVE(2), .ADDR_W(AW), .SIZE_W(SW),
               .TID_W(TW), .TIME_W(MW), .SEQ_W(12)) uut (.*);

   task automatic chk(input string req, input string what, input int act, input int exp);
      n_run++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s %s: got %0d expected %0d", req, what, act, exp);
      end
   endtask

   // driven at a falling edge, returns at the next falling edge with the op cleared
   task automatic cmd(input int op, input int idx, input int a, input int sz,
                      input bit sec, input int tid, input int tm, input bit fl);
      cmd_op = 4'(op); cmd_idx = 3'(idx); cmd_addr = AW'(a); cmd_size = SW'(sz);
      cmd_secure = sec; cmd_tid = TW'(tid); cmd_time = MW'(tm); cmd_flag = fl;
      @(negedge clk);
      cmd_op = '0; cmd_flag = 1'b0;
   endtask

   task automatic look(input int a, input int sz, input bit sec);
      lk_addr = AW'(a); lk_size = SW'(sz); lk_secure = sec;
      #1;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!finished) begin
         n_fail++;
         $display("FAIL watchdog: got 1 expected 0");
         $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // reset state
      chk("R1", "reset empty", int'(empty), 1);
      chk("R1", "reset full", int'(full), 0);
      chk("R1", "reset alloc_idx", int'(alloc_idx), 0);
      chk("R5", "reset issue_valid", int'(issue_valid), 0);
      chk("R10", "reset drained", int'(drained), 0);

      cmd(8, 0, 0, 0, 0, 0, 0, 0);
      chk("R10", "drain when empty", int'(drained), 1);
      chk("R10", "no pulse when empty", int'(drain_done), 0);

      // five allocations: {addr,size,sec,tid,time}
      chk("R1", "alloc_idx 0", int'(alloc_idx), 0);  cmd(1, 0, 'h10, 4, 0, 0, 5, 0);
      chk("R1", "alloc_idx 1", int'(alloc_idx), 1);  cmd(1, 0, 'h20, 4, 1, 1, 3, 0);
      chk("R1", "alloc_idx 2", int'(alloc_idx), 2);  cmd(1, 0, 'h30, 4, 0, 0, 5, 0);
      chk("R1", "alloc_idx 3", int'(alloc_idx), 3);  cmd(1, 0, 'h10, 4, 0, 1, 9, 0);
      chk("R1", "alloc_idx 4", int'(alloc_idx), 4);  cmd(1, 0, 'h40, 4, 0, 1, 3, 0);
      chk("R1", "full after 5", int'(full), 1);
      chk("R1", "count 5", int'(alloc_cnt), 5);
      chk("R10", "alloc clears drained", int'(drained), 0);
      chk("R5", "head earliest time", int'(issue_idx), 1);

      cmd(1, 0, 'h70, 4, 0, 0, 0, 0);
      chk("R2", "alloc_err pulse", int'(alloc_err), 1);
      chk("R2", "count unchanged", int'(alloc_cnt), 5);
      look('h70, 1, 0);
      chk("R2", "refused block not tracked", int'(match_hit), 0);

      look('h10, 1, 0);
      chk("R3", "exact hit", int'(match_hit), 1);
      chk("R3", "earliest allocated", int'(match_idx), 0);
      look('h10, 1, 1);
      chk("R3", "secure mismatch", int'(match_hit), 0);
      look('h20, 1, 1);
      chk("R3", "secure hit idx", int'(match_idx), 1);
      look('h12, 1, 0);
      chk("R4", "overlap hit", int'(ovl_hit), 1);
      chk("R4", "overlap first in order", int'(ovl_idx), 0);

      cmd(3, 1, 0, 0, 0, 0, 0, 0);
      chk("R7", "svc count", int'(svc_cnt), 1);
      chk("R7", "head after serve", int'(issue_idx), 4);
      look('h20, 1, 1);
      chk("R4", "in-service excluded", int'(ovl_hit), 0);
      chk("R3", "in-service still matches", int'(match_hit), 1);

      cmd(5, 3, 0, 0, 0, 0, 0, 0);
      chk("R6", "to head", int'(issue_idx), 3);
      cmd(5, 1, 0, 0, 0, 0, 0, 0);
      chk("R6", "in-service ignored", int'(issue_idx), 3);
      chk("R6", "in-service kept", int'(svc_cnt), 1);

      cmd(4, 1, 0, 0, 0, 0, 0, 0);
      chk("R8", "repend svc count", int'(svc_cnt), 0);
      chk("R8", "head kept", int'(issue_idx), 3);
      cmd(3, 3, 0, 0, 0, 0, 0, 0);
      chk("R8", "equal time older first", int'(issue_idx), 4);
      cmd(3, 4, 0, 0, 0, 0, 0, 0);
      chk("R8", "repended next", int'(issue_idx), 1);
      chk("R7", "svc count 2", int'(svc_cnt), 2);

      cmd(7, 0, 0, 0, 0, 0, 0, 1);
      chk("R12", "unfull pulse", int'(unfull_pulse), 1);
      chk("R12", "count after pop", int'(alloc_cnt), 4);
      chk("R9", "freed entry next", int'(alloc_idx), 0);
      cmd(7, 2, 0, 0, 0, 0, 0, 0);
      chk("R12", "pop with targets keeps", int'(alloc_cnt), 4);
      chk("R12", "no pulse", int'(unfull_pulse), 0);
      cmd(7, 2, 0, 0, 0, 0, 0, 1);
      chk("R12", "no pulse when not full", int'(unfull_pulse), 0);
      chk("R9", "last freed on top", int'(alloc_idx), 2);

      cmd(2, 3, 0, 0, 0, 0, 0, 0);
      chk("R9", "release in service svc", int'(svc_cnt), 1);
      chk("R9", "release count", int'(alloc_cnt), 2);
      chk("R9", "release free head", int'(alloc_idx), 3);

      cmd(6, 0, 0, 0, 0, 1, 0, 0);
      chk("R11", "squash count", int'(alloc_cnt), 1);
      chk("R11", "in-service stays", int'(svc_cnt), 1);
      chk("R11", "no waiting", int'(issue_valid), 0);
      chk("R11", "squashed entry free", int'(alloc_idx), 1);

      cmd(1, 0, 'h50, 4, 0, 2, 0, 0);
      chk("R5", "new head", int'(issue_idx), 1);
      cmd(3, 1, 0, 0, 0, 0, 0, 1);
      chk("R7", "no-resp releases", int'(alloc_cnt), 1);
      chk("R7", "no-resp svc", int'(svc_cnt), 1);

      cmd(8, 0, 0, 0, 0, 0, 0, 0);
      chk("R10", "draining not drained", int'(drained), 0);
      chk("R10", "no early pulse", int'(drain_done), 0);
      cmd(2, 4, 0, 0, 0, 0, 0, 0);
      chk("R10", "drain_done pulse", int'(drain_done), 1);
      chk("R10", "drained", int'(drained), 1);
      chk("R9", "empty", int'(empty), 1);
      @(negedge clk);
      chk("R10", "pulse one cycle", int'(drain_done), 0);

      // overlap and exact sweep around one entry at 0x40 size 4
      cmd(1, 0, 'h40, 4, 0, 0, 0, 0);
      for (int a = 'h38; a < 'h48; a++) begin
         for (int s = 1; s <= 4; s++) begin
            for (int sec = 0; sec < 2; sec++) begin
               int exp_o;
               look(a, s, sec[0]);
               exp_o = (sec == 0 && a < 'h44 && a + s > 'h40) ? 1 : 0;
               chk("R4", $sformatf("overlap a=%0d s=%0d sec=%0d", a, s, sec), int'(ovl_hit), exp_o);
               chk("R3", $sformatf("exact a=%0d sec=%0d", a, sec), int'(match_hit),
                   (sec == 0 && a == 'h40) ? 1 : 0);
            end
         end
      end

      finished = 1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule